// File: doc/BRIEF.md
# Aligned Multiple Word-Length Adder

This block is a purely combinational two's-complement adder for fixed-point datapaths in which every signal may carry its own word length. Operand A, operand B and the result each get a width from their own parameter. Operand B sits at a fixed binary-point offset relative to A: its least significant bit weighs `2**B_SHL` units of A's least significant bit. The offset is applied by bit placement only. No shifter is built.

The full-precision sum is one bit wider than the wider of the two aligned operands. Its top `DROP_MSB` bits are known to be copies of the sign, so they are removed. The bits that remain below the `OUT_W`-bit result field are cut off. The adder is a ripple-carry chain that covers only the bits that survive the top-bit drop. Cells below the result field produce only a carry. The caller orders the operands so that A has the finer least significant bit, which keeps the offset non-negative.

Top module: `aln_mwl_adder`

## Requirements
- R1: With `FULL_W = max(A_W, B_W + B_SHL) + 1`, `WORK_W = FULL_W - DROP_MSB` and `TRUNC = WORK_W - OUT_W`, `res_o` equals bits `[WORK_W-1:TRUNC]` of the signed sum `a_i + b_i * 2**B_SHL`, computed at full precision, for every parameter set the bench instantiates.
- R2: The weight of `b_i` is `2**B_SHL`. When `TRUNC < B_SHL`, result bits `[B_SHL-TRUNC-1:0]` equal `a_i[B_SHL-1:TRUNC]`.
- R3: A legal configuration satisfies `WORK_W >= A_W`, `WORK_W - B_SHL >= B_W` and `1 <= OUT_W <= WORK_W`. With `OUT_W = WORK_W`, the whole surviving sum appears on `res_o`, including its extreme values.
- R4: The top `DROP_MSB` bits of the full sum never appear in the result. The caller guarantees that these bits equal the sign. Under that guarantee, sums at both ends of the reduced range come out exact.
- R5: The low `TRUNC` bits of the sum are discarded. The result is the sum divided by `2**TRUNC`, rounded down.
- R6: For negative sums with non-zero discarded bits, the result rounds toward negative infinity. For example, -1 with two bits discarded gives -1.
- R7: With `B_SHL = 0`, `DROP_MSB = 0` and `TRUNC = 0`, `res_o` is the ordinary signed sum, one bit wider than the wider input.
- R8: A carry generated entirely inside the discarded low bits propagates into the kept result field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_W | Operand A, signed, finer LSB |
| b_i | input | B_W | Operand B, signed, LSB weight 2**B_SHL relative to A |
| res_o | output | OUT_W | Signed sum after top-bit drop and low-bit truncation |

## Verification
The bench first targets rounding on negative sums. A design that rounded toward zero, or that sign-extended the discarded bits the wrong way, would return 0 instead of -1 for small negative values. Second, it targets sums at the edges of the reduced range after the top-bit drop. A design that kept the wrong field would wrap or lose the sign there.

It also adds two low fields that carry out into the kept field. A design that left out the carry-only cells would come up one short. With a non-zero offset it checks that the low result bits follow A alone. A misplaced B would corrupt them.

// File: rtl/aln_pkg.sv
package aln_pkg;
  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/aln_sext.sv
module aln_sext #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] d_o
);
  generate
    if (OUT_W > IN_W) begin : g_ext
      assign d_o = {{(OUT_W-IN_W){d_i[IN_W-1]}}, d_i};
    end else begin : g_same
      assign d_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/aln_ripple.sv
module aln_ripple #(
  parameter int W        = 9,
  parameter int LOW_PASS = 3,
  parameter int KEEP_LO  = 2
) (
  input  logic [W-1:0]          a_i,
  input  logic [W-LOW_PASS-1:0] b_hi_i,
  output logic [W-KEEP_LO-1:0]  sum_o
);
  logic [W-1:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic b_bit;
    // below the offset B contributes nothing; cell reduces to wiring
    if (i < LOW_PASS) begin : g_nob
      assign b_bit = 1'b0;
    end else begin : g_b
      assign b_bit = b_hi_i[i-LOW_PASS];
    end
    if (i < W-1) begin : g_cy
      assign carry[i+1] = (a_i[i] & b_bit) | ((a_i[i] ^ b_bit) & carry[i]);
    end
    // carry-only below the kept field
    if (i >= KEEP_LO) begin : g_sum
      assign sum_o[i-KEEP_LO] = a_i[i] ^ b_bit ^ carry[i];
    end
  end
endmodule

// File: rtl/aln_mwl_adder.sv
module aln_mwl_adder #(
  parameter int A_W      = 8,
  parameter int B_W      = 6,
  parameter int B_SHL    = 3,
  parameter int OUT_W    = 7,
  parameter int DROP_MSB = 1
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [OUT_W-1:0] res_o
);
  import aln_pkg::*;

  localparam int FULL_W = imax(A_W, B_W + B_SHL) + 1;
  localparam int WORK_W = FULL_W - DROP_MSB;
  localparam int TRUNC  = WORK_W - OUT_W;
  localparam int BHI_W  = WORK_W - B_SHL;

  logic [WORK_W-1:0] a_ext;
  logic [BHI_W-1:0]  b_ext;

  aln_sext #(.IN_W(A_W), .OUT_W(WORK_W)) u_a_ext (.d_i(a_i), .d_o(a_ext));
  aln_sext #(.IN_W(B_W), .OUT_W(BHI_W))  u_b_ext (.d_i(b_i), .d_o(b_ext));

  aln_ripple #(
    .W(WORK_W), .LOW_PASS(B_SHL), .KEEP_LO(TRUNC)
  ) u_ripple (
    .a_i(a_ext), .b_hi_i(b_ext), .sum_o(res_o)
  );

  // full-precision reference for the assertions
  localparam logic [FULL_W-1:0] KEEP_MASK = {FULL_W{1'b1}} << TRUNC;
  logic signed [FULL_W-1:0] a_full, b_full, ref_full, res_full;
  always_comb begin
    a_full   = FULL_W'($signed(a_i));
    b_full   = FULL_W'($signed(b_i)) <<< B_SHL;
    ref_full = a_full + b_full;
    res_full = FULL_W'($signed(res_o)) <<< TRUNC;
  end

  always_comb begin
    a_r4_msb_redundant: assert ($countones(ref_full[FULL_W-1 -: DROP_MSB+1]) == 0 ||
                                $countones(ref_full[FULL_W-1 -: DROP_MSB+1]) == DROP_MSB+1);
  end

  always_comb begin
    a_r5_kept_field: assert (res_full == (ref_full & KEEP_MASK));
  end

  generate
    if (TRUNC > 0) begin : g_floor
      always_comb begin
        a_r6_floor: assert (res_full <= ref_full);
      end
    end
    if (TRUNC < B_SHL && B_SHL <= A_W) begin : g_low
      always_comb begin
        a_r2_low_from_a: assert (res_o[B_SHL-TRUNC-1:0] == a_i[B_SHL-1:TRUNC]);
      end
    end
    if (B_SHL == 0 && DROP_MSB == 0 && TRUNC == 0) begin : g_plain
      always_comb begin
        a_r7_plain_sum: assert ($signed(res_o) == ($signed(a_full) + $signed(b_full)));
      end
    end
  endgenerate
endmodule

// File: tb/aln_mwl_adder_tb_top.sv
module aln_mwl_adder_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // dut_i: A_W=8 B_W=6 B_SHL=3 OUT_W=7 DROP_MSB=1 -> TRUNC=2
  logic [7:0] a0; logic [5:0] b0; logic [6:0] r0;
  // d2: 6/6, shl 0, out 4, drop 0 -> TRUNC=3
  logic [5:0] a2; logic [5:0] b2; logic [3:0] r2;
  // d3: 5/3, shl 0, out 6, drop 0 -> TRUNC=0
  logic [4:0] a3; logic [2:0] b3; logic [5:0] r3;
  // d4: 4/4, shl 2, out 7, drop 0 -> TRUNC=0
  logic [3:0] a4; logic [3:0] b4; logic [6:0] r4;

  aln_mwl_adder #(.A_W(8), .B_W(6), .B_SHL(3), .OUT_W(7), .DROP_MSB(1))
    dut_i (.a_i(a0), .b_i(b0), .res_o(r0));
  aln_mwl_adder #(.A_W(6), .B_W(6), .B_SHL(0), .OUT_W(4), .DROP_MSB(0))
    dut2_i (.a_i(a2), .b_i(b2), .res_o(r2));
  aln_mwl_adder #(.A_W(5), .B_W(3), .B_SHL(0), .OUT_W(6), .DROP_MSB(0))
    dut3_i (.a_i(a3), .b_i(b3), .res_o(r3));
  aln_mwl_adder #(.A_W(4), .B_W(4), .B_SHL(2), .OUT_W(7), .DROP_MSB(0))
    dut4_i (.a_i(a4), .b_i(b4), .res_o(r4));

  // {a, b, expected} for dut_i: result = floor((a + 8*b) / 4)
  localparam int NV = 7;
  localparam logic [20:0] VEC [NV] = '{
    {8'h00, 6'h00, 7'h00},
    {8'h03, 6'h00, 7'h00},
    {8'hFF, 6'h00, 7'h7F},
    {8'h04, 6'h01, 7'h03},
    {8'h7F, 6'h10, 7'h3F},
    {8'h80, 6'h30, 7'h40},
    {8'hF9, 6'h3F, 7'h7C}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic longint model(input longint a, input longint b, input int shl,
                                   input int trunc, input int out_w);
    longint s;
    s = a + b * (longint'(1) << shl);
    s = s >>> trunc;
    return s & ((longint'(1) << out_w) - 1);
  endfunction

  initial begin
    a0 = '0; b0 = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0; a4 = '0; b4 = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle zero", 32'(r0), 32'h0);

    for (int k = 0; k < NV; k++) begin
      a0 = VEC[k][20:13]; b0 = VEC[k][12:7];
      @(negedge clk);
      check("R5 table", 32'(r0), 32'(VEC[k][6:0]));
    end

    // R4 range edges after top-bit drop
    a0 = 8'h7F; b0 = 6'h10; @(negedge clk); check("R4 max", 32'(r0), 32'h3F);
    a0 = 8'h80; b0 = 6'h30; @(negedge clk); check("R4 min", 32'(r0), 32'h40);
    // R6 floor on negatives
    a0 = 8'hFF; b0 = 6'h00; @(negedge clk); check("R6 neg one", 32'(r0), 32'h7F);
    a2 = 6'h3F; b2 = 6'h3F; @(negedge clk); check("R6 d2 -2/8", 32'(r2), 32'hF);
    // R8 carry out of truncated bits
    a2 = 6'h05; b2 = 6'h03; @(negedge clk); check("R8 carry in", 32'(r2), 32'h1);
    a2 = 6'h07; b2 = 6'h01; @(negedge clk); check("R8 carry ripple", 32'(r2), 32'h1);
    // R7 plain sum
    a3 = 5'h0F; b3 = 3'h3; @(negedge clk); check("R7 plain pos", 32'(r3), 32'h12);
    a3 = 5'h10; b3 = 3'h4; @(negedge clk); check("R3 full width min", 32'(r3), 32'h2C);
    // R2 offset alignment
    a4 = 4'hF; b4 = 4'h1; @(negedge clk); check("R2 shifted b", 32'(r4), 32'h03);
    check("R2 low bits from a", 32'(r4[1:0]), 32'(a4[1:0]));
    a4 = 4'h8; b4 = 4'h8; @(negedge clk); check("R2 both min", 32'(r4), 32'h58);
    a4 = 4'h7; b4 = 4'h7; @(negedge clk); check("R2 both max", 32'(r4), 32'h23);

    // R1 random sweep across all parameter sets
    for (int n = 0; n < 300; n++) begin
      longint ra, rb, s;
      ra = longint'($urandom_range(255)) - 128;
      rb = longint'($urandom_range(63)) - 32;
      s = ra + rb * 8;
      if (s < -256 || s > 255) rb = 0;
      a0 = 8'(ra); b0 = 6'(rb);
      a2 = 6'($urandom_range(63)); b2 = 6'($urandom_range(63));
      a3 = 5'($urandom_range(31)); b3 = 3'($urandom_range(7));
      a4 = 4'($urandom_range(15)); b4 = 4'($urandom_range(15));
      @(negedge clk);
      check("R1 rand d1", 32'(r0), 32'(model(ra, rb, 3, 2, 7)));
      check("R1 rand d2", 32'(r2),
            32'(model(longint'($signed(a2)), longint'($signed(b2)), 0, 3, 4)));
      check("R1 rand d3", 32'(r3),
            32'(model(longint'($signed(a3)), longint'($signed(b3)), 0, 0, 6)));
      check("R1 rand d4", 32'(r4),
            32'(model(longint'($signed(a4)), longint'($signed(b4)), 2, 0, 7)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule